// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one decrementing timer channel. A prescaler slows the peripheral clock by 1, 16 or 256, and on each prescaled tick the count drops by one. The counter can run free and wrap to its all-ones value. It can run periodic and reload from a programmed reload value. It can also run one-shot and stop at zero. The count width is 16 or 32 bits. In 16-bit mode only the lower half of the count register moves.

Software reaches the channel through a write strobe and a read select. Two registers set the reload value. One of them also loads the count at once. The other leaves the count alone, so the new value takes effect at the next reload. A raw flag records each decrement to zero. The flag ANDed with the interrupt enable drives the interrupt pin. Any write to the clear register drops the raw flag.

Top module: `dcnt_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable only). The reload register reads 0, the count reads 0xFFFFFFFF, and the raw flag, the masked flag and `irq` are all 0.
- R2: Register select codes are: 0 reload-and-count, 1 count (read only), 2 control, 3 interrupt clear (write only), 4 raw flag, 5 masked flag, 6 reload only. The control fields are: bit 0 one-shot, bit 1 width (1 = 32-bit), bits 3:2 prescale code, bit 5 interrupt enable, bit 6 mode (1 = periodic, 0 = free-running), bit 7 enable. Every other control bit reads 0. The flags read in bit 0.
- R3: The prescale code selects a divide of 1, 16 or 256. Code 3 acts as code 2. The divider restarts when enable is set. The first decrement comes on the Nth clock edge after the edge that writes enable, and later ones follow every N edges. The edge that clears enable still counts a tick that is due. No decrement happens while enable is clear.
- R4: In periodic mode a tick at zero reloads the count from the reload register, cut to the active width. With a reload value of zero the count stays at zero.
- R5: In free-running mode a tick at zero wraps the active width to all ones, whatever the reload register holds.
- R6: A write to select 0 stores the full data word in both the reload register and the count. It wins over a decrement in the same cycle.
- R7: A write to select 6 changes only the reload register. The count keeps decrementing undisturbed.
- R8: The raw flag sets on a tick that takes the count from 1 to 0. It stays set until a write to select 3. If the set and the clear fall in the same cycle, the set wins.
- R9: The masked flag and `irq` equal the raw flag ANDed with the interrupt enable bit.
- R10: In one-shot mode the count stops at zero and raises no further events. Writing a nonzero value through select 0 while enabled starts it counting again.
- R11: In 16-bit mode decrements, reloads and wraps change only bits 15:0 of the count. Bits 31:16 keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Read data for `rd_sel`, combinational |
| irq | output | 1 | Channel interrupt (masked flag) |

## Verification
Two collisions can fall on one clock edge here. In the first, a write to the clear register meets the tick that takes the count from 1 to 0. In the second, a reload-and-count write meets a scheduled decrement. The bench sets up the first case by loading a count of 1 with a divide of 1. It then writes enable and the clear on two consecutive edges, and expects the raw flag and `irq` to stay high. It sets up the second case by writing the count while the counter is running. It then expects the count to hold exactly the written value, not one less.

// File: rtl/dcnt_pkg.sv
// Package: register select codes and control field positions shared by the
// timer channel and its bench. Assumes a 3-bit register select.
package dcnt_pkg;

    localparam logic [2:0] SEL_LOAD   = 3'd0;
    localparam logic [2:0] SEL_VALUE  = 3'd1;
    localparam logic [2:0] SEL_CTRL   = 3'd2;
    localparam logic [2:0] SEL_CLR    = 3'd3;
    localparam logic [2:0] SEL_RAW    = 3'd4;
    localparam logic [2:0] SEL_MASKED = 3'd5;
    localparam logic [2:0] SEL_BGLOAD = 3'd6;

    localparam int B_ONESHOT  = 0;
    localparam int B_SIZE     = 1;
    localparam int B_PRESC_LO = 2;
    localparam int B_INTEN    = 5;
    localparam int B_MODE     = 6;
    localparam int B_ENABLE   = 7;

    typedef struct packed {
        logic       en;
        logic       periodic;
        logic       inten;
        logic [1:0] presc;
        logic       size;
        logic       oneshot;
    } ctrl_t;

endpackage

// File: rtl/dcnt_prescale.sv
// Prescaler: emits a one-cycle tick every 1, 2^SHIFT or 2^(2*SHIFT) clocks
// while enabled. Assumes code 3 acts as code 2. The divider is held at zero
// while disabled, so it restarts on each enable.
module dcnt_prescale #(
    parameter int SHIFT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] code,
    output logic       tick
);
    localparam int PRE_W = 2 * SHIFT;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] div_m1;

    // Terminal count for the selected divide.
    always_comb begin
        case (code)
            2'd0:    div_m1 = '0;
            2'd1:    div_m1 = PRE_W'((1 << SHIFT) - 1);
            default: div_m1 = '1;
        endcase
    end

    assign tick = en && (pre_cnt >= div_m1);

    // Divider count: held at zero while disabled, restarted after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_cnt <= '0;
        else if (!en)      pre_cnt <= '0;
        else if (tick)     pre_cnt <= '0;
        else               pre_cnt <= pre_cnt + 1'b1;
    end

    // R3: the divider starts from zero when enable rises.
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (pre_cnt == '0));

endmodule

// File: rtl/dcnt_core.sv
// Count core: holds the count value and the raw interrupt flag. It applies
// load writes, decrements, reloads, wraps and the one-shot halt. Assumes a
// load write wins over a tick, and a raw-flag set wins over a clear.
module dcnt_core #(
    parameter int CNT_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             size,
    input  logic             periodic,
    input  logic             oneshot,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_data,
    input  logic             clr_wr,
    output logic [CNT_W-1:0] value,
    output logic             raw
);
    localparam int UP_W = CNT_W - HALF_W;

    logic cur_zero;
    logic cur_one;
    logic [CNT_W-1:0] next_dec;
    logic [CNT_W-1:0] next_zero;

    // Zero and one detection over the active width.
    always_comb begin
        if (size) begin
            cur_zero = (value == '0);
            cur_one  = (value == CNT_W'(1));
        end else begin
            cur_zero = (value[HALF_W-1:0] == '0);
            cur_one  = (value[HALF_W-1:0] == HALF_W'(1));
        end
    end

    // Next count for a plain decrement and for a tick at zero.
    always_comb begin
        if (size) next_dec = value - 1'b1;
        else      next_dec = {value[CNT_W-1:HALF_W], value[HALF_W-1:0] - 1'b1};
        if (oneshot)       next_zero = value;
        else if (periodic) next_zero = size ? load_val
                                            : {value[CNT_W-1:HALF_W], load_val[HALF_W-1:0]};
        else               next_zero = size ? '1
                                            : {value[CNT_W-1:HALF_W], {HALF_W{1'b1}}};
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        value <= '1;
        else if (load_wr)  value <= load_data;
        else if (tick)     value <= cur_zero ? next_zero : next_dec;
    end

    // Raw flag: set on the 1 -> 0 decrement, cleared by a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)                               raw <= 1'b0;
        else if (tick && !load_wr && cur_one)     raw <= 1'b1;
        else if (clr_wr)                          raw <= 1'b0;
    end

    // R8: a decrement to zero always leaves the raw flag set.
    p_raw_on_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_wr && cur_one) |=> raw);

    // R6: a load write lands exactly, despite any tick.
    p_load_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (value == $past(load_data)));

    // R10: a halted one-shot count does not move.
    p_oneshot_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && oneshot && cur_zero && !load_wr) |=> $stable(value));

    // R4: a periodic tick at zero reloads the low half from the reload value.
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !oneshot && periodic && cur_zero && !load_wr)
        |=> (value[HALF_W-1:0] == $past(load_val[HALF_W-1:0])));

    // R11: in 16-bit mode the upper half holds unless a load write occurs.
    p_upper_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!size && !load_wr) |=> (value[CNT_W-1:HALF_W] == $past(value[CNT_W-1:HALF_W])));

    logic [UP_W-1:0] unused_up;
    assign unused_up = '0;

endmodule

// File: rtl/dcnt_timer.sv
// Timer channel top: holds the control and reload registers, decodes write
// strobes, muxes read data and drives the masked interrupt. Assumes single-
// cycle write strobes and a combinational read path.
module dcnt_timer #(
    parameter int CNT_W     = 32,
    parameter int HALF_W    = 16,
    parameter int PRE_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    import dcnt_pkg::*;

    localparam int CTRL_W = 8;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] value;
    logic             raw;
    logic             tick;
    logic             masked;
    logic             load_wr;
    logic             clr_wr;
    logic [CTRL_W-1:0] ctrl_rd;

    assign load_wr = wr_en && (wr_sel == SEL_LOAD);
    assign clr_wr  = wr_en && (wr_sel == SEL_CLR);

    // Control register: only the defined fields are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            ctrl.inten <= 1'b1;
        end else if (wr_en && wr_sel == SEL_CTRL) begin
            ctrl.oneshot  <= wr_data[B_ONESHOT];
            ctrl.size     <= wr_data[B_SIZE];
            ctrl.presc    <= wr_data[B_PRESC_LO +: 2];
            ctrl.inten    <= wr_data[B_INTEN];
            ctrl.periodic <= wr_data[B_MODE];
            ctrl.en       <= wr_data[B_ENABLE];
        end
    end

    // Reload register: written by both load selects.
    always_ff @(posedge clk) begin
        if (!rst_n)                                             load_val <= '0;
        else if (wr_en && (wr_sel == SEL_LOAD || wr_sel == SEL_BGLOAD)) load_val <= wr_data;
    end

    dcnt_prescale #(.SHIFT(PRE_SHIFT)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctrl.en),
        .code (ctrl.presc),
        .tick (tick)
    );

    dcnt_core #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .size     (ctrl.size),
        .periodic (ctrl.periodic),
        .oneshot  (ctrl.oneshot),
        .load_val (load_val),
        .load_wr  (load_wr),
        .load_data(wr_data),
        .clr_wr   (clr_wr),
        .value    (value),
        .raw      (raw)
    );

    assign masked = raw && ctrl.inten;
    assign irq    = masked;

    // Control read image with reserved bits at zero.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[B_ONESHOT]       = ctrl.oneshot;
        ctrl_rd[B_SIZE]          = ctrl.size;
        ctrl_rd[B_PRESC_LO +: 2] = ctrl.presc;
        ctrl_rd[B_INTEN]         = ctrl.inten;
        ctrl_rd[B_MODE]          = ctrl.periodic;
        ctrl_rd[B_ENABLE]        = ctrl.en;
    end

    // Read data mux.
    always_comb begin
        case (rd_sel)
            SEL_LOAD, SEL_BGLOAD: rd_data = load_val;
            SEL_VALUE:            rd_data = value;
            SEL_CTRL:             rd_data = CNT_W'(ctrl_rd);
            SEL_RAW:              rd_data = CNT_W'(raw);
            SEL_MASKED:           rd_data = CNT_W'(masked);
            default:              rd_data = '0;
        endcase
    end

    // R2: reserved control bits read as zero.
    p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_CTRL) |-> (rd_data[CNT_W-1:CTRL_W] == '0 && rd_data[4] == 1'b0));

    // R9: with interrupts disabled the pin stays low.
    p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.inten |-> !irq);

endmodule

// File: tb/test_dcnt_timer.sv
// Bench for dcnt_timer: a vector table walked by one loop, then directed
// reset, collision and masking tests.
module test_dcnt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [2:0]  rd_sel = 3'd0;
    logic [31:0] rd_data;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dcnt_timer i_dcnt_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  wsel;
        logic [31:0] wdata;
        logic [15:0] idle;
        logic [2:0]  rsel;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    // Selects: 0 load, 1 value, 2 ctrl, 3 clr, 4 raw, 5 masked, 6 bgload.
    localparam int NV = 45;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd0, 32'd10,        16'd0,   3'd1, 32'd10,        4'd6},  // R6
        '{1'b1, 3'd2, 32'hE2,        16'd0,   3'd2, 32'hE2,        4'd2},  // R2
        '{1'b0, 3'd0, 32'd0,         16'd4,   3'd1, 32'd5,         4'd3},  // R3
        '{1'b0, 3'd0, 32'd0,         16'd4,   3'd4, 32'd1,         4'd8},  // R8
        '{1'b0, 3'd0, 32'd0,         16'd0,   3'd1, 32'd10,        4'd4},  // R4
        '{1'b0, 3'd0, 32'd0,         16'd0,   3'd5, 32'd1,         4'd9},  // R9
        '{1'b1, 3'd3, 32'd0,         16'd0,   3'd4, 32'd0,         4'd8},  // R8
        '{1'b1, 3'd6, 32'd3,         16'd0,   3'd1, 32'd7,         4'd7},  // R7
        '{1'b0, 3'd0, 32'd0,         16'd5,   3'd1, 32'd1,         4'd4},  // R4
        '{1'b0, 3'd0, 32'd0,         16'd1,   3'd1, 32'd3,         4'd4},  // R4
        '{1'b0, 3'd0, 32'd0,         16'd0,   3'd0, 32'd3,         4'd7},  // R7
        '{1'b1, 3'd2, 32'h62,        16'd0,   3'd1, 32'd1,         4'd3},  // R3
        '{1'b0, 3'd0, 32'd0,         16'd3,   3'd1, 32'd1,         4'd3},  // R3
        '{1'b1, 3'd2, 32'h20,        16'd0,   3'd4, 32'd1,         4'd8},  // R8
        '{1'b1, 3'd3, 32'd0,         16'd0,   3'd5, 32'd0,         4'd9},  // R9
        '{1'b1, 3'd0, 32'h12340002,  16'd0,   3'd1, 32'h12340002,  4'd6},  // R6
        '{1'b1, 3'd2, 32'hA0,        16'd0,   3'd1, 32'h12340002,  4'd11}, // R11
        '{1'b0, 3'd0, 32'd0,         16'd1,   3'd1, 32'h12340000,  4'd11}, // R11
        '{1'b0, 3'd0, 32'd0,         16'd0,   3'd1, 32'h1234FFFF,  4'd5},  // R5
        '{1'b0, 3'd0, 32'd0,         16'd0,   3'd4, 32'd1,         4'd8},  // R8
        '{1'b1, 3'd2, 32'h20,        16'd0,   3'd1, 32'h1234FFFD,  4'd11}, // R11
        '{1'b1, 3'd3, 32'd0,         16'd0,   3'd4, 32'd0,         4'd8},  // R8
        '{1'b1, 3'd0, 32'd2,         16'd0,   3'd1, 32'd2,         4'd6},  // R6
        '{1'b1, 3'd2, 32'hA3,        16'd0,   3'd1, 32'd2,         4'd10}, // R10
        '{1'b0, 3'd0, 32'd0,         16'd3,   3'd1, 32'd0,         4'd10}, // R10
        '{1'b0, 3'd0, 32'd0,         16'd0,   3'd4, 32'd1,         4'd10}, // R10
        '{1'b1, 3'd0, 32'd5,         16'd0,   3'd1, 32'd5,         4'd10}, // R10
        '{1'b0, 3'd0, 32'd0,         16'd0,   3'd1, 32'd4,         4'd10}, // R10
        '{1'b1, 3'd2, 32'h22,        16'd0,   3'd1, 32'd3,         4'd3},  // R3
        '{1'b1, 3'd2, 32'hC2,        16'd0,   3'd1, 32'd3,         4'd4},  // R4
        '{1'b1, 3'd0, 32'd0,         16'd0,   3'd1, 32'd0,         4'd6},  // R6
        '{1'b0, 3'd0, 32'd0,         16'd5,   3'd1, 32'd0,         4'd4},  // R4
        '{1'b1, 3'd2, 32'h42,        16'd0,   3'd1, 32'd0,         4'd4},  // R4
        '{1'b1, 3'd0, 32'd100,       16'd0,   3'd1, 32'd100,       4'd6},  // R6
        '{1'b1, 3'd2, 32'hC6,        16'd0,   3'd1, 32'd100,       4'd3},  // R3
        '{1'b0, 3'd0, 32'd0,         16'd14,  3'd1, 32'd100,       4'd3},  // R3
        '{1'b0, 3'd0, 32'd0,         16'd0,   3'd1, 32'd99,        4'd3},  // R3
        '{1'b0, 3'd0, 32'd0,         16'd14,  3'd1, 32'd99,        4'd3},  // R3
        '{1'b0, 3'd0, 32'd0,         16'd0,   3'd1, 32'd98,        4'd3},  // R3
        '{1'b1, 3'd2, 32'h42,        16'd0,   3'd2, 32'h42,        4'd2},  // R2
        '{1'b1, 3'd2, 32'hCE,        16'd0,   3'd2, 32'hCE,        4'd2},  // R2
        '{1'b0, 3'd0, 32'd0,         16'd254, 3'd1, 32'd98,        4'd3},  // R3
        '{1'b0, 3'd0, 32'd0,         16'd0,   3'd1, 32'd97,        4'd3},  // R3
        '{1'b1, 3'd6, 32'd7,         16'd0,   3'd1, 32'd97,        4'd7},  // R7
        '{1'b1, 3'd2, 32'hFFFFFFFF,  16'd0,   3'd2, 32'hEF,        4'd2}   // R2
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] expv);
        n_run++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, expv);
        end
    endtask

    // One write (or idle) cycle, then idle cycles; returns at a falling edge.
    task automatic step(input logic wr, input logic [2:0] sel, input logic [31:0] data,
                        input int idle);
        wr_en   = wr;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        for (int k = 0; k < idle; k++) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd2, v); check("R1 ctrl", v, 32'h20);
        rd(3'd0, v); check("R1 load", v, 32'h0);
        rd(3'd1, v); check("R1 value", v, 32'hFFFFFFFF);
        rd(3'd4, v); check("R1 raw", v, 32'h0);
        rd(3'd5, v); check("R1 masked", v, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].wsel, VEC[i].wdata, int'(VEC[i].idle));
            rd(VEC[i].rsel, v);
            check($sformatf("R%0d vec %0d", VEC[i].req, i), v, VEC[i].expv);
        end

        // R8 collision: clear write on the same edge as the 1 -> 0 decrement.
        step(1'b1, 3'd2, 32'h42, 0);
        step(1'b1, 3'd0, 32'd1, 0);
        step(1'b1, 3'd3, 32'd0, 0);
        step(1'b1, 3'd2, 32'hE2, 0);
        step(1'b1, 3'd3, 32'd0, 0);
        rd(3'd4, v); check("R8 set beats clear", v, 32'h1);
        check("R9 irq high", {31'd0, irq}, 32'h1);

        // R9 masking: interrupt enable off hides a set raw flag.
        step(1'b1, 3'd2, 32'h42, 0);
        rd(3'd4, v); check("R9 raw kept", v, 32'h1);
        rd(3'd5, v); check("R9 masked low", v, 32'h0);
        check("R9 irq low", {31'd0, irq}, 32'h0);

        // R6 collision: load write while running at divide 1.
        step(1'b1, 3'd2, 32'hC2, 0);
        step(1'b1, 3'd0, 32'd50, 0);
        rd(3'd1, v); check("R6 load beats tick", v, 32'd50);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule